// File: doc/BRIEF.md
# Wide-Range Encoded Output Divider

This block divides a fast source clock by a ratio anywhere from 2 to 8232. The ratio is not given as a binary count. It comes in a 15-bit encoded control word. The three low bits of the word pick one of three encodings:

- a direct code for the smallest ratios;
- an inverted-offset code for mid-range ratios;
- a wide code for large ratios. This one multiplies a base value by a power of two, so the step between available ratios grows from 1 to 2, 4 and 8 as the ratio gets larger.

Every ratio gives a near-50% output. Odd ratios are handled by combining a rising-edge phase with a falling-edge phase.

Software or a neighbouring block writes the control word and raises the enable input. The divider reads a new word only at the start of an output period, so the period already in progress always finishes at its old length. A word that does not decode to a legal ratio holds the output low and raises an error flag until a legal word arrives. The decoded active ratio is brought out so that neighbouring logic can check the setting.

Top module: `wr_out_div`

## Requirements
- R1: While `rst` is high, and after it is released until the first load, `clk_out`, `ratio_out` and `code_err` are all 0.
- R2: Wide mode is selected when `ctrl_word[2:0]` = 101.
  - The fields are M = `ctrl_word[14:6]`, S = `ctrl_word[5:4]` and b = `ctrl_word[3]`.
  - The ratio is ((M+3)*2+b)*2^S, which gives a range of 38 to 8232.
  - A wide code that yields a ratio below 38 is illegal.
- R3: Mid mode is selected when `ctrl_word[2:0]` = 100. The ratio is the bitwise inverse of `ctrl_word[7:3]` plus 6, which gives 6 to 37.
- R4: Small mode is selected when `ctrl_word[2:0]` = 110.
  - The ratio is `ctrl_word[6:3]` + 2, for field values 0 to 11 (ratios 2 to 13).
  - Field values 12 to 15 are illegal.
- R5: While running with ratio N, successive rising edges of `clk_out` are exactly N source clock periods apart.
- R6: The high phase of `clk_out` lasts N/2 source periods. For odd N this is a whole number of periods plus one half period.
- R7: A change of `ctrl_word` takes effect only at the next output period boundary. The period in progress completes with the old ratio.
- R8: Any illegal word has the same effect. Illegal words are mode codes other than 100, 101 and 110, plus the out-of-range values in R2 and R4.
  - From the next period boundary, `clk_out` is held at 0, `ratio_out` reads 0 and `code_err` reads 1.
  - A later legal word restarts the output.
- R9: When `enable` is low, `clk_out`, `ratio_out` and `code_err` are 0 after the next clock edge. When `enable` is raised with a legal even ratio, `clk_out` rises at the first clock edge that samples it high.
- R10: `ratio_out` shows the decoded ratio from the same clock edge at which the first period with that ratio starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 15 | Encoded ratio word |
| enable | input | 1 | Run enable; low forces the output off |
| clk_out | output | 1 | Divided clock |
| ratio_out | output | 14 | Active decoded ratio, 0 when stopped or illegal |
| code_err | output | 1 | Active word is illegal |

## Verification
`ratio_out` and `code_err` change at the clock edge that starts a new output period. That edge is one edge after the word is seen when the divider is stopped, or the wrap edge of the current period when it is running. The bench therefore samples them at least one source period after that edge.

The rise of `clk_out` comes from that same edge for even ratios and half a period later for odd ratios. The word may change at either point in a period. For that reason the bench lets one output rise pass after each word change, then time-stamps the next rise, fall and rise to measure the period and the high time.

The disable response and the first rise after re-enabling are both checked one nanosecond after the single clock edge that produces them.

// File: rtl/wrdiv_pkg.sv
package wrdiv_pkg;

    localparam int FIELD_W    = 15;
    localparam int RATIO_W    = 14;
    localparam int M_W        = 9;
    localparam int S_W        = 2;
    localparam int MID_W      = 5;
    localparam int MID_LSB    = 3;
    localparam int SMALL_W    = 4;
    localparam int SMALL_LSB  = 3;
    localparam int MID_OFFSET = 6;
    localparam int SMALL_OFF  = 2;
    localparam int SMALL_TOP  = 13;
    localparam int WIDE_MIN   = 38;
    localparam int RATIO_MAX  = (((2**M_W) - 1 + 3) * 2 + 1) * (2**((2**S_W) - 1));

    typedef enum logic [2:0] {
        MODE_MID   = 3'b100,
        MODE_WIDE  = 3'b101,
        MODE_SMALL = 3'b110
    } mode_e;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [S_W-1:0] s;
        logic           b;
        logic [2:0]     mode;
    } field_t;

    typedef struct packed {
        logic               ok;
        logic [RATIO_W-1:0] ratio;
    } ratio_t;

    function automatic ratio_t decode_wide(field_t f);
        ratio_t             r;
        logic [RATIO_W-1:0] base;
        base    = RATIO_W'(f.m) + RATIO_W'(3);
        base    = {base[RATIO_W-2:0], f.b};
        r.ratio = base << f.s;
        r.ok    = (r.ratio >= RATIO_W'(WIDE_MIN));
        if (!r.ok) r.ratio = '0;
        return r;
    endfunction

    function automatic ratio_t decode_mid(logic [FIELD_W-1:0] w);
        ratio_t           r;
        logic [MID_W-1:0] inv;
        inv     = ~w[MID_LSB +: MID_W];
        r.ratio = RATIO_W'(inv) + RATIO_W'(MID_OFFSET);
        r.ok    = 1'b1;
        return r;
    endfunction

    function automatic ratio_t decode_small(logic [FIELD_W-1:0] w);
        ratio_t             r;
        logic [SMALL_W-1:0] code;
        code    = w[SMALL_LSB +: SMALL_W];
        r.ok    = (code <= SMALL_W'(SMALL_TOP - SMALL_OFF));
        r.ratio = r.ok ? RATIO_W'(code) + RATIO_W'(SMALL_OFF) : '0;
        return r;
    endfunction

endpackage

// File: rtl/wrdiv_decode.sv
module wrdiv_decode
    import wrdiv_pkg::*;
(
    input  logic [FIELD_W-1:0] word,
    output ratio_t             dec
);

    field_t fld;
    assign fld = field_t'(word);

    always_comb begin
        case (fld.mode)
            MODE_WIDE:  dec = decode_wide(fld);
            MODE_MID:   dec = decode_mid(word);
            MODE_SMALL: dec = decode_small(word);
            default:    dec = '{ok: 1'b0, ratio: '0};
        endcase
    end

    // R2 / R4: a legal decode always lands inside the supported span
    always_comb begin
        if (dec.ok) begin
            assert_dec_span_R2: assert (dec.ratio >= RATIO_W'(2) && dec.ratio <= RATIO_W'(RATIO_MAX));
        end
    end

endmodule

// File: rtl/wrdiv_core.sv
module wrdiv_core #(
    parameter int RATIO_W = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               next_ok,
    input  logic [RATIO_W-1:0] next_ratio,
    output logic               clk_out,
    output logic [RATIO_W-1:0] ratio_now,
    output logic               err
);

    logic [RATIO_W-1:0] cnt;
    logic [RATIO_W-1:0] act_ratio;
    logic [RATIO_W-1:0] cnt_nxt;
    logic [RATIO_W:0]   hi_len;
    logic               run;
    logic               wrap;
    logic               load;
    logic               q_pos;
    logic               q_neg;

    assign wrap    = run && (cnt == act_ratio - RATIO_W'(1));
    assign load    = !run || wrap;
    assign cnt_nxt = cnt + RATIO_W'(1);
    assign hi_len  = ({1'b0, act_ratio} + (RATIO_W+1)'(1)) >> 1;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt       <= '0;
            act_ratio <= '0;
            run       <= 1'b0;
            err       <= 1'b0;
            q_pos     <= 1'b0;
        end else if (load) begin
            cnt       <= '0;
            act_ratio <= next_ok ? next_ratio : '0;
            run       <= next_ok;
            err       <= !next_ok;
            q_pos     <= next_ok;
        end else begin
            cnt       <= cnt_nxt;
            q_pos     <= ({1'b0, cnt_nxt} < hi_len);
        end
    end

    // half-period delayed copy that trims odd ratios to an even split
    always_ff @(negedge clk) begin
        if (rst) q_neg <= 1'b0;
        else     q_neg <= q_pos;
    end

    assign clk_out   = act_ratio[0] ? (q_pos & q_neg) : q_pos;
    assign ratio_now = act_ratio;

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < act_ratio));

    assert_hold_in_period_R7: assert property (@(posedge clk) disable iff (rst)
        (enable && run && !wrap) |=> $stable(act_ratio));

    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        err |-> (!clk_out && ratio_now == '0 && !run));

    assert_first_high_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (q_pos && cnt == '0));

endmodule

// File: rtl/wr_out_div.sv
module wr_out_div
    import wrdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [FIELD_W-1:0] ctrl_word,
    input  logic               enable,
    output logic               clk_out,
    output logic [RATIO_W-1:0] ratio_out,
    output logic               code_err
);

    ratio_t dec;

    wrdiv_decode u_decode (
        .word (ctrl_word),
        .dec  (dec)
    );

    wrdiv_core #(.RATIO_W(RATIO_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .next_ok    (dec.ok),
        .next_ratio (dec.ratio),
        .clk_out    (clk_out),
        .ratio_now  (ratio_out),
        .err        (code_err)
    );

    assert_off_when_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!clk_out && ratio_out == '0 && !code_err));

    assert_ratio_span_R4: assert property (@(posedge clk) disable iff (rst)
        (ratio_out != '0) |-> (ratio_out >= RATIO_W'(2) && ratio_out <= RATIO_W'(RATIO_MAX)));

    assert_err_excl_R8: assert property (@(posedge clk) disable iff (rst)
        code_err |-> (ratio_out == '0));

endmodule

// File: tb/test_wr_out_div.sv
module test_wr_out_div;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic [14:0] ctrl_word;
    logic        clk_out;
    logic [13:0] ratio_out;
    logic        code_err;

    int checks = 0;
    int errors = 0;

    always #(HALF) clk = ~clk;

    wr_out_div i_wr_out_div (
        .clk       (clk),
        .rst       (rst),
        .ctrl_word (ctrl_word),
        .enable    (enable),
        .clk_out   (clk_out),
        .ratio_out (ratio_out),
        .code_err  (code_err)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [14:0] w_wide(int m, int b, int s);
        logic [8:0] mm;
        logic [1:0] ss;
        logic       bb;
        mm = 9'(m);
        ss = 2'(s);
        bb = b[0];
        return {mm, ss, bb, 3'b101};
    endfunction

    function automatic int wide_ratio(int m, int b, int s);
        return ((m + 3) * 2 + b) * (1 << s);
    endfunction

    function automatic logic [14:0] w_mid(int n);
        logic [4:0] v;
        v = 5'(n - 6);
        return {7'b0, ~v, 3'b100};
    endfunction

    function automatic logic [14:0] w_small(int code);
        logic [3:0] c;
        c = 4'(code);
        return {8'b0, c, 3'b110};
    endfunction

    // apply a word, let one output rise pass, then time one full period
    task automatic run_ratio(input logic [14:0] w, input int n, input string req);
        longint t0, t1, t2;
        tick();
        ctrl_word = w;
        @(posedge clk_out);
        @(posedge clk_out);
        t0 = $time;
        @(negedge clk_out);
        t1 = $time;
        @(posedge clk_out);
        t2 = $time;
        check("R5", $sformatf("period ns for ratio %0d", n), t2 - t0, longint'(n) * CLK_PERIOD);
        check("R6", $sformatf("high ns for ratio %0d", n), t1 - t0, longint'(n) * HALF);
        tick();
        check(req, $sformatf("ratio_out for ratio %0d", n), ratio_out, n);
        check(req, "code_err on legal word", code_err, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        enable = 1'b1;
        ctrl_word = w_mid(10);
        repeat (3) tick();
        check("R1", "clk_out in reset", clk_out, 0);
        check("R1", "ratio_out in reset", ratio_out, 0);
        check("R1", "code_err in reset", code_err, 0);
        rst = 1'b0;
    endtask

    task automatic t_mid_mode();
        run_ratio(w_mid(6), 6, "R3");
        run_ratio(w_mid(37), 37, "R3");
        run_ratio(w_mid(14), 14, "R3");
        run_ratio(w_mid(21), 21, "R3");
    endtask

    task automatic t_small_mode();
        run_ratio(w_small(0), 2, "R4");
        run_ratio(w_small(1), 3, "R4");
        run_ratio(w_small(11), 13, "R4");
        run_ratio(w_small(5), 7, "R4");
    endtask

    task automatic t_wide_mode();
        run_ratio(w_wide(16, 0, 0), wide_ratio(16, 0, 0), "R2");
        run_ratio(w_wide(35, 1, 0), wide_ratio(35, 1, 0), "R2");
        run_ratio(w_wide(16, 1, 2), wide_ratio(16, 1, 2), "R2");
        run_ratio(w_wide(0, 0, 3), wide_ratio(0, 0, 3), "R2");
        run_ratio(w_wide(511, 1, 0), wide_ratio(511, 1, 0), "R2");
        run_ratio(w_wide(511, 1, 1), wide_ratio(511, 1, 1), "R2");
        run_ratio(w_wide(511, 1, 3), wide_ratio(511, 1, 3), "R2");
    endtask

    task automatic t_switch_boundary();
        longint r0, r1, r2;
        run_ratio(w_mid(10), 10, "R7");
        @(posedge clk_out);
        r0 = $time;
        repeat (3) tick();
        ctrl_word = w_mid(20);
        @(posedge clk_out);
        r1 = $time;
        @(posedge clk_out);
        r2 = $time;
        check("R7", "old period completes", r1 - r0, 10 * CLK_PERIOD);
        check("R7", "new period after boundary", r2 - r1, 20 * CLK_PERIOD);
    endtask

    task automatic bad_word(input logic [14:0] w, input string what);
        int highs;
        tick();
        ctrl_word = w;
        repeat (45) tick();
        highs = 0;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (clk_out) highs++;
        end
        check("R8", {what, " clk_out high samples"}, highs, 0);
        check("R8", {what, " code_err"}, code_err, 1);
        check("R8", {what, " ratio_out"}, ratio_out, 0);
    endtask

    task automatic t_invalid_codes();
        run_ratio(w_mid(20), 20, "R8");
        bad_word(15'b000_0000_0000_0000, "mode 000");
        bad_word(15'h7FFF, "mode 111");
        bad_word(w_small(13), "small code 13");
        bad_word(w_wide(0, 0, 0), "wide ratio 6");
        run_ratio(w_mid(12), 12, "R8");
    endtask

    task automatic t_enable();
        int highs;
        run_ratio(w_mid(10), 10, "R9");
        tick();
        enable = 1'b0;
        @(posedge clk);
        #1;
        check("R9", "clk_out after disable", clk_out, 0);
        check("R9", "ratio_out after disable", ratio_out, 0);
        check("R9", "code_err after disable", code_err, 0);
        highs = 0;
        for (int i = 0; i < 15; i++) begin
            tick();
            if (clk_out) highs++;
        end
        check("R9", "clk_out high while disabled", highs, 0);
        ctrl_word = w_mid(12);
        tick();
        enable = 1'b1;
        @(posedge clk);
        #1;
        check("R9", "clk_out at first enabled edge", clk_out, 1);
        check("R10", "ratio_out at first period", ratio_out, 12);
        run_ratio(w_mid(12), 12, "R10");
        tick();
        rst = 1'b1;
        tick();
        check("R1", "clk_out after mid-run reset", clk_out, 0);
        check("R1", "ratio_out after mid-run reset", ratio_out, 0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R5 watchdog: got %0d cycles expected fewer", WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_mid_mode();
        t_small_mode();
        t_wide_mode();
        t_switch_boundary();
        t_invalid_codes();
        t_enable();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule